// File: doc/BRIEF.md
# Interrupt Delegation and Pending-View Unit

This unit sits beside the control-register file of a small hart with machine, supervisor and user privilege levels. It holds the interrupt delegation word and the software-settable pending bits. It builds the machine-level pending word from those bits and from four raw interrupt lines. From that word it derives what supervisor software sees when it reads pending and enable state. It also decides, combinationally and for every cycle, whether an interrupt should be taken now, at which privilege level it is handled, and which interrupt index wins.

Delegation is decided per interrupt index and nothing else. An interrupt keeps the same bit position in every view. The machine timer interrupt can never be handed to supervisor software, because its delegation bit is hardwired to zero. That pending bit follows the timer line directly. Register writes cannot clear it; only the timer unit can drop it.

Top module: `irq_deleg_unit`

## Requirements
- R1: After reset the delegation word and all stored pending bits are zero, so with all interrupt lines low every readable word (select 0, 1, 2) returns 0 and no trap is requested.
- R2: Writing select 0 (delegation) stores only bits 1, 5 and 9. Every other bit, including 3, 7 and 11, reads back as zero. Select 3 reads zero, and a write to select 3 changes nothing.
- R3: The machine pending word (select 1) shows the machine software line at bit 3, the machine timer line at bit 7 and the machine external line at bit 11. It shows stored bits at 1, 5 and 9, and bit 9 is also set while the supervisor external line is high. All other bits read zero.
- R4: A write to select 1 updates only the stored bits 1, 5 and 9, on the next clock edge. Bits 3, 7 and 11 keep following their lines, so writing 0 never clears a high machine timer line.
- R5: The supervisor pending word (select 2) equals the machine pending word ANDed with the delegation word, bit for bit at the same positions.
- R6: A write to select 2 can change only stored bit 1, and only while delegation bit 1 is set. Bits 5 and 9 of the write are ignored.
- R7: The supervisor enable view output equals the machine enable input ANDed with the delegation word.
- R8: An undelegated interrupt that is pending and enabled requests a machine-level trap when the privilege is below machine (code 0 user, 1 supervisor, 3 machine) or the machine global enable is set.
- R9: A delegated interrupt that is pending and enabled requests a supervisor-level trap when the privilege is not machine and either the privilege is user or the supervisor global enable is set.
- R10: When several interrupts qualify, machine-level ones beat supervisor-level ones. Among the machine-level ones the index order is 11, 3, 7, 9, 1, 5. Among the supervisor-level ones it is 9, 1, 5. The winning index is reported.
- R11: The trap outputs are combinational in the present inputs and register state. A delegation write changes them only after the next clock edge.
- R12: The machine timer interrupt (index 7) is never visible in the supervisor pending word and never produces a supervisor-level trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| mie_i | input | 12 | Machine interrupt enable word |
| irq_msoft_i | input | 1 | Machine software interrupt line |
| irq_mtimer_i | input | 1 | Machine timer line from the memory-mapped timer |
| irq_mext_i | input | 1 | Machine external interrupt line |
| irq_sext_i | input | 1 | Supervisor external interrupt line |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 2 | Register select: 0 delegation, 1 machine pending, 2 supervisor pending, 3 none |
| csr_wdata_i | input | 12 | Write data |
| csr_rdata_o | output | 12 | Read data of the selected word |
| sie_o | output | 12 | Supervisor view of the enable word |
| trap_req_o | output | 1 | An interrupt trap should be taken |
| trap_to_s_o | output | 1 | The trap is handled at supervisor level (0 means machine) |
| trap_idx_o | output | 4 | Index of the winning interrupt |

## Verification
The bench sweeps every combination of the three delegable bits, the three stored pending bits, the three machine lines, the three privilege levels and both global enables, under two enable words. For each case it compares the trap decision and the supervisor pending word against a model computed from the rules. A design that ignored the privilege in the machine-level condition would miss traps taken from user mode while the machine global enable is clear. A design that swapped the priority order would report the wrong index whenever external and timer interrupts arrive together. Directed cases go after a write of zero to the machine pending word while the timer line is high, which a faulty design would clear. They also cover supervisor writes to bits 5 and 9, and a supervisor write to bit 1 while bit 1 is undelegated, which a faulty design would store. Finally they check that a delegation write does not move the trap decision until the following edge.

// File: rtl/irq_deleg_pkg.sv
package irq_deleg_pkg;

  // Interrupt bit positions inside the pending, enable and delegation words
  localparam int IDX_SSI = 1;
  localparam int IDX_MSI = 3;
  localparam int IDX_STI = 5;
  localparam int IDX_MTI = 7;
  localparam int IDX_SEI = 9;
  localparam int IDX_MEI = 11;

  // Number of interrupt sources that take part in arbitration
  localparam int NUM_SRC = 6;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_M = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    SEL_DELEG = 2'd0,
    SEL_MPEND = 2'd1,
    SEL_SPEND = 2'd2,
    SEL_NONE  = 2'd3
  } csr_sel_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/irq_deleg_reg.sv
module irq_deleg_reg #(
  parameter int          W    = 12,
  parameter logic [W-1:0] MASK = 12'h222
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] deleg_o
);

  logic [W-1:0] deleg_q;
  logic [W-1:0] deleg_d;

  always_comb begin
    deleg_d = deleg_q;
    if (wr_en_i) begin
      deleg_d = wr_data_i & MASK;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          deleg_q[i] <= 1'b0;
        end else if (wr_en_i) begin
          deleg_q[i] <= deleg_d[i];
        end
      end
    end else begin : g_zero
      assign deleg_q[i] = 1'b0;
    end
  end

  assign deleg_o = deleg_q;

  AST_DELEG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> deleg_o == ($past(wr_data_i) & MASK)); // R2

  AST_DELEG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(deleg_o)); // R11

endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_deleg_pkg::*;
#(
  parameter int           W       = 12,
  parameter logic [W-1:0] SW_MASK = 12'h222
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         m_wr_i,
  input  logic         s_wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] deleg_i,
  input  logic         msoft_i,
  input  logic         mtimer_i,
  input  logic         mext_i,
  input  logic         sext_i,
  output logic [W-1:0] mpend_o
);

  localparam logic [W-1:0] SSI_BIT = W'(1) << IDX_SSI;

  logic [W-1:0] sw_q;
  logic [W-1:0] sw_d;
  logic [W-1:0] line_vec;
  logic         sw_en;

  assign sw_en = m_wr_i | s_wr_i;

  always_comb begin
    sw_d = sw_q;
    if (m_wr_i) begin
      sw_d = wr_data_i & SW_MASK;
    end else if (s_wr_i && deleg_i[IDX_SSI]) begin
      sw_d[IDX_SSI] = wr_data_i[IDX_SSI];
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (SW_MASK[i]) begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sw_q[i] <= 1'b0;
        end else if (sw_en) begin
          sw_q[i] <= sw_d[i];
        end
      end
    end else begin : g_zero
      assign sw_q[i] = 1'b0;
    end
  end

  always_comb begin
    line_vec          = '0;
    line_vec[IDX_MSI] = msoft_i;
    line_vec[IDX_MTI] = mtimer_i;
    line_vec[IDX_MEI] = mext_i;
    line_vec[IDX_SEI] = sext_i;
  end

  assign mpend_o = sw_q | line_vec;

  AST_SPEND_WRITE_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wr_i && !m_wr_i) |=> (sw_q & ~SSI_BIT) == $past(sw_q & ~SSI_BIT)); // R6

  AST_SPEND_WRITE_UNDELEG: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wr_i && !m_wr_i && !deleg_i[IDX_SSI]) |=> $stable(sw_q)); // R6

  AST_MPEND_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    m_wr_i |=> (sw_q == ($past(wr_data_i) & SW_MASK))); // R4

endmodule

// File: rtl/irq_trap_arb.sv
module irq_trap_arb
  import irq_deleg_pkg::*;
#(
  parameter int W     = 12,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     pend_i,
  input  logic [W-1:0]     en_i,
  input  logic [W-1:0]     deleg_i,
  input  logic [1:0]       priv_i,
  input  logic             m_gie_i,
  input  logic             s_gie_i,
  output logic             req_o,
  output logic             to_s_o,
  output logic [IDX_W-1:0] idx_o
);

  // Highest priority first: external, software, timer; machine before supervisor
  localparam int ORDER [NUM_SRC] = '{IDX_MEI, IDX_MSI, IDX_MTI, IDX_SEI, IDX_SSI, IDX_STI};

  logic         in_m;
  logic         in_u;
  logic         m_ok;
  logic         s_ok;
  logic [W-1:0] m_cand;
  logic [W-1:0] s_cand;
  logic [W-1:0] pick;
  logic         m_hit;
  logic         s_hit;

  always_comb begin
    in_m   = (priv_i == 2'(PRIV_M));
    in_u   = (priv_i == 2'(PRIV_U));
    m_ok   = !in_m || m_gie_i;
    s_ok   = !in_m && (in_u || s_gie_i);
    m_cand = pend_i & en_i & ~deleg_i & {W{m_ok}};
    s_cand = pend_i & en_i &  deleg_i & {W{s_ok}};
    m_hit  = |m_cand;
    s_hit  = |s_cand;
    pick   = m_hit ? m_cand : s_cand;
  end

  always_comb begin
    idx_o = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (pick[ORDER[k]]) begin
        idx_o = IDX_W'(ORDER[k]);
      end
    end
  end

  assign req_o  = m_hit | s_hit;
  assign to_s_o = !m_hit && s_hit;

endmodule

// File: rtl/irq_deleg_unit.sv
module irq_deleg_unit
  import irq_deleg_pkg::*;
#(
  parameter int           W          = 12,
  parameter logic [W-1:0] DELEG_MASK = 12'h222,
  parameter logic [W-1:0] SW_MASK    = 12'h222,
  parameter int           IDX_W      = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       priv_i,
  input  logic             m_gie_i,
  input  logic             s_gie_i,
  input  logic [W-1:0]     mie_i,
  input  logic             irq_msoft_i,
  input  logic             irq_mtimer_i,
  input  logic             irq_mext_i,
  input  logic             irq_sext_i,
  input  logic             csr_we_i,
  input  logic [1:0]       csr_sel_i,
  input  logic [W-1:0]     csr_wdata_i,
  output logic [W-1:0]     csr_rdata_o,
  output logic [W-1:0]     sie_o,
  output logic             trap_req_o,
  output logic             trap_to_s_o,
  output logic [IDX_W-1:0] trap_idx_o
);

  csr_sel_e     sel;
  logic         rst_sync_n;
  logic [W-1:0] deleg;
  logic [W-1:0] mpend;
  logic [W-1:0] spend;
  logic         deleg_wr;
  logic         mpend_wr;
  logic         spend_wr;

  assign sel      = csr_sel_e'(csr_sel_i);
  assign deleg_wr = csr_we_i && (sel == SEL_DELEG);
  assign mpend_wr = csr_we_i && (sel == SEL_MPEND);
  assign spend_wr = csr_we_i && (sel == SEL_SPEND);

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_deleg_reg #(.W(W), .MASK(DELEG_MASK)) u_deleg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (deleg_wr),
    .wr_data_i (csr_wdata_i),
    .deleg_o   (deleg)
  );

  irq_pend_reg #(.W(W), .SW_MASK(SW_MASK)) u_pend (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .m_wr_i    (mpend_wr),
    .s_wr_i    (spend_wr),
    .wr_data_i (csr_wdata_i),
    .deleg_i   (deleg),
    .msoft_i   (irq_msoft_i),
    .mtimer_i  (irq_mtimer_i),
    .mext_i    (irq_mext_i),
    .sext_i    (irq_sext_i),
    .mpend_o   (mpend)
  );

  irq_trap_arb #(.W(W), .IDX_W(IDX_W)) u_arb (
    .pend_i  (mpend),
    .en_i    (mie_i),
    .deleg_i (deleg),
    .priv_i  (priv_i),
    .m_gie_i (m_gie_i),
    .s_gie_i (s_gie_i),
    .req_o   (trap_req_o),
    .to_s_o  (trap_to_s_o),
    .idx_o   (trap_idx_o)
  );

  // Supervisor views keep every bit at its machine position
  assign spend = mpend & deleg;
  assign sie_o = mie_i & deleg;

  always_comb begin
    unique case (sel)
      SEL_DELEG: csr_rdata_o = deleg;
      SEL_MPEND: csr_rdata_o = mpend;
      SEL_SPEND: csr_rdata_o = spend;
      default:   csr_rdata_o = '0;
    endcase
  end

  AST_TRAP_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_req_o |-> (mpend[trap_idx_o] && mie_i[trap_idx_o])); // R8

  AST_S_TRAP_NOT_FROM_M: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trap_req_o && trap_to_s_o) |-> (priv_i != 2'(PRIV_M))); // R9

  AST_S_TRAP_DELEGATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trap_req_o && trap_to_s_o) |-> deleg[trap_idx_o]); // R10

  AST_MTI_STAYS_MACHINE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trap_req_o && trap_to_s_o) |-> (trap_idx_o != IDX_W'(IDX_MTI))); // R12

  AST_MTIP_SURVIVES_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mpend_wr && irq_mtimer_i) |=> (mpend[IDX_MTI] == irq_mtimer_i)); // R4

endmodule

// File: tb/irq_deleg_unit_tb.sv
`timescale 1ns/1ps
module irq_deleg_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  priv;
  logic        m_gie, s_gie;
  logic [11:0] mie;
  logic        l_msoft, l_mtimer, l_mext, l_sext;
  logic        we;
  logic [1:0]  sel;
  logic [11:0] wdata;
  logic [11:0] rdata;
  logic [11:0] sie;
  logic        t_req, t_to_s;
  logic [3:0]  t_idx;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  irq_deleg_unit u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .priv_i       (priv),
    .m_gie_i      (m_gie),
    .s_gie_i      (s_gie),
    .mie_i        (mie),
    .irq_msoft_i  (l_msoft),
    .irq_mtimer_i (l_mtimer),
    .irq_mext_i   (l_mext),
    .irq_sext_i   (l_sext),
    .csr_we_i     (we),
    .csr_sel_i    (sel),
    .csr_wdata_i  (wdata),
    .csr_rdata_o  (rdata),
    .sie_o        (sie),
    .trap_req_o   (t_req),
    .trap_to_s_o  (t_to_s),
    .trap_idx_o   (t_idx)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [1:0] s, input logic [11:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic csr_rd(input logic [1:0] s, output logic [11:0] d);
    sel = s;
    #1;
    d = rdata;
  endtask

  // Reference trap decision from the requirements: {req, to_s, idx}
  function automatic logic [5:0] model(input logic [11:0] pend, input logic [11:0] en,
                                       input logic [11:0] dl, input logic [1:0] pv,
                                       input logic mg, input logic sg);
    int ord [6] = '{11, 3, 7, 9, 1, 5};
    logic mok = (pv != 2'd3) || mg;
    logic sok = (pv != 2'd3) && ((pv == 2'd0) || sg);
    for (int k = 0; k < 6; k++)
      if (pend[ord[k]] && en[ord[k]] && !dl[ord[k]] && mok) return {2'b10, 4'(ord[k])};
    for (int k = 0; k < 6; k++)
      if (pend[ord[k]] && en[ord[k]] && dl[ord[k]] && sok) return {2'b11, 4'(ord[k])};
    return 6'd0;
  endfunction

  initial begin
    logic [11:0] rd;
    logic [1:0]  pv_list [3] = '{2'd0, 2'd1, 2'd3};
    logic [11:0] mie_list [2] = '{12'hFFF, 12'h2A8};
    rst_n = 1'b0; priv = 2'd3; m_gie = 1'b0; s_gie = 1'b0; mie = 12'h000;
    l_msoft = 0; l_mtimer = 0; l_mext = 0; l_sext = 0;
    we = 0; sel = 2'd0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    csr_rd(2'd0, rd); chk("R1 deleg after reset", rd, 0);
    csr_rd(2'd1, rd); chk("R1 mpend after reset", rd, 0);
    csr_rd(2'd2, rd); chk("R1 spend after reset", rd, 0);
    mie = 12'hFFF; priv = 2'd0; #1;
    chk("R1 no trap after reset", t_req, 0);

    // R2: writable delegation bits, select 3 inert
    csr_wr(2'd0, 12'hFFF);
    csr_rd(2'd0, rd); chk("R2 deleg keeps 1,5,9 only", rd, 12'h222);
    csr_wr(2'd3, 12'h000);
    csr_rd(2'd0, rd); chk("R2 select 3 write ignored", rd, 12'h222);
    csr_rd(2'd3, rd); chk("R2 select 3 reads zero", rd, 0);

    // R7: supervisor enable view
    mie = 12'hFFF; #1; chk("R7 sie with deleg 222", sie, 12'h222);

    // R4/R12: machine pending write cannot clear timer line
    l_mtimer = 1;
    csr_wr(2'd1, 12'hFFF);
    csr_rd(2'd1, rd); chk("R4 mpend after write FFF", rd, 12'h2A2);
    csr_wr(2'd1, 12'h000);
    csr_rd(2'd1, rd); chk("R4 timer bit survives write 0", rd, 12'h080);
    csr_rd(2'd2, rd); chk("R12 timer hidden in spend", rd, 12'h000);
    priv = 2'd1; m_gie = 0; s_gie = 1; #1;
    chk("R12 timer traps to machine", {t_req, t_to_s, t_idx}, {2'b10, 4'd7});
    l_mtimer = 0;

    // R3: lines and supervisor external OR
    l_msoft = 1; l_mext = 1; l_sext = 1;
    csr_rd(2'd1, rd); chk("R3 lines in mpend", rd, 12'hA08);
    l_msoft = 0; l_mext = 0; l_sext = 0;

    // R6: supervisor pending writes
    csr_wr(2'd2, 12'hFFF);
    csr_rd(2'd1, rd); chk("R6 spend write sets only bit 1", rd, 12'h002);
    csr_wr(2'd2, 12'h000);
    csr_wr(2'd0, 12'h200);
    csr_wr(2'd2, 12'h002);
    csr_rd(2'd1, rd); chk("R6 spend write ignored when bit1 undelegated", rd, 12'h000);

    // R11: delegation write timing, STI pending in supervisor mode
    csr_wr(2'd0, 12'h000);
    csr_wr(2'd1, 12'h020);
    priv = 2'd1; m_gie = 1; s_gie = 1; mie = 12'hFFF;
    @(negedge clk);
    we = 1; sel = 2'd0; wdata = 12'h020;
    #1; chk("R11 before edge still machine", {t_req, t_to_s, t_idx}, {2'b10, 4'd5});
    @(posedge clk); #1;
    chk("R11 after edge supervisor", {t_req, t_to_s, t_idx}, {2'b11, 4'd5});
    @(negedge clk); we = 0;
    csr_wr(2'd1, 12'h000);

    // R5/R8/R9/R10: near-exhaustive sweep
    for (int mp = 0; mp < 2; mp++) begin
      mie = mie_list[mp];
      for (int dl = 0; dl < 8; dl++) begin
        logic [11:0] dw = {2'b0, dl[2], 3'b0, dl[1], 3'b0, dl[0], 1'b0};
        csr_wr(2'd0, dw);
        for (int sw = 0; sw < 8; sw++) begin
          logic [11:0] sww = {2'b0, sw[2], 3'b0, sw[1], 3'b0, sw[0], 1'b0};
          csr_wr(2'd1, sww);
          sel = 2'd2;
          for (int ln = 0; ln < 8; ln++) begin
            logic [11:0] pend;
            l_msoft = ln[0]; l_mtimer = ln[1]; l_mext = ln[2];
            pend = sww | {ln[2], 3'b0, ln[1], 3'b0, ln[0], 3'b0};
            for (int p = 0; p < 3; p++) begin
              for (int g = 0; g < 4; g++) begin
                priv = pv_list[p]; m_gie = g[0]; s_gie = g[1];
                #1;
                chk("R5 spend view", rdata, pend & dw);
                chk("R8 R9 R10 trap decision", {t_req, t_to_s, t_idx},
                    model(pend, mie, dw, priv, m_gie, s_gie));
              end
            end
          end
        end
      end
    end
    l_msoft = 0; l_mtimer = 0; l_mext = 0;
    summary();
  end

endmodule